// File: doc/BRIEF.md
# ECC Word Store with Stale-Code Tolerance

This block is an on-chip word store for 64-bit data in which each word carries three pieces of protection: eight SECDED check bits, one parity bit per byte, and a flag that says whether the check bits still match the data. A host issues single-word reads and writes, and each write has a byte-enable mask. A write that enables every byte stores a fresh code. A write that enables only some bytes merges those bytes in place and marks the code stale. It does not read the old word to rebuild the code. The per-byte parity is updated on every write, so it always matches the data.

A read of a word whose code is current goes through full single-error correction and double-error detection. A read of a stale word is checked only by its byte parity. When that check passes, the controller rebuilds the code in a write-back cycle. During idle cycles a background walker visits the addresses in turn and refreshes any stale word whose parity is clean. A mode input turns off all read-side checking, but codes are still generated on writes. A fault-injection mask lets the integrator flip stored data bits after the code and parity are computed, which makes the checking paths reachable from the ports.

Top module: `ecc_mem_ctrl`

## Requirements
- R1: A write with all eight byte enables set stores the data with a freshly computed code and marks the code current. A following read returns the same data with both error flags low, and `ready` stays high.
- R2: A write with some but not all enables set replaces only the enabled bytes (enable bit b covers data bits 8b+7..8b) and marks the code stale. `ready` stays high after it. A write with no enables set changes nothing.
- R3: A read of a stale word checks each byte against its parity bit. On a mismatch it returns the stored data unchanged, pulses `err_uncorr`, and leaves the word stale, so later reads flag it again.
- R4: A read of a stale word with clean parity returns the data with no flags and rebuilds the code in the next cycle, during which `ready` is low. A later read of that word needs no write-back.
- R5: A read of a word with a current code and one flipped data bit returns the corrected data and pulses `err_corr` with the read data. It also stores the corrected word during the following cycle with `ready` low, so a second read is clean.
- R6: A read of a word with a current code and two flipped data bits returns the raw stored data and pulses `err_uncorr`. No write-back follows.
- R7: While `chk_disable` is high on a read, the raw stored data is returned with both flags low and no write-back. Codes are still generated on writes made in this mode, so correction works once the mode is cleared.
- R8: In each cycle where `req_valid` is low and `ready` is high, the walker visits one address (ascending, wrapping). It refreshes a stale, parity-clean word to a current code and leaves a parity-failing word stale.
- R9: The walker does not move or write while `req_valid` is high. A stale word stays stale through any run of back-to-back host requests.
- R10: A read accepted at a clock edge (`req_valid` and `ready` high, `req_write` low) presents `rdata_valid`, `rdata` and the flags after the next edge. `ready` is low only in the single write-back cycle.
- R11: On a write, the stored bits of the enabled bytes are the write data XOR `inj_mask`. The code and parity are computed from the unflipped write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_disable | input | 1 | Suppress read-side checking and write-back |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| inj_mask | input | 64 | Data bits flipped on store (fault injection) |
| ready | output | 1 | Request can be accepted this cycle |
| rdata_valid | output | 1 | Read response present |
| rdata | output | 64 | Read data |
| err_corr | output | 1 | Single-bit error corrected on this response |
| err_uncorr | output | 1 | Uncorrectable error on this response |

## Verification
The bench injects one- and two-bit faults into words with a current code. A design that miscomputed the syndrome would return wrong data, raise the wrong flag, or skip the repair, and a second read of the same word would show the stale fault again. It makes stale words through partial writes and reads them with and without a parity fault. A design that trusted stale check bits would flag false corrections. One that rewrote a parity-failing word would silence the error on the next read. It holds host traffic busy for longer than a full walker sweep, then checks that a stale word still needs repair. Separately, it idles the store and checks that the word no longer needs repair. A walker that ran under host traffic, or that never ran, shows up in the `ready` pattern of the following read.

// File: rtl/ecc_mem_pkg.sv
// Package: shared constants and code functions for the 64-bit word store.
// Assumes a 64-bit data word; the code is an extended Hamming (72,64) code
// with codeword positions 1..71, check bits at power-of-two positions.
package ecc_mem_pkg;
    localparam int WORD_W   = 64;
    localparam int CODE_W   = 8;
    localparam int NBYTES   = WORD_W / 8;
    localparam int LAST_POS = WORD_W + CODE_W - 1;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              corr;
        logic              uncorr;
    } dec_t;

    // Encode: seven Hamming bits plus an overall parity bit on top.
    function automatic logic [CODE_W-1:0] secded_encode(input logic [WORD_W-1:0] d);
        logic [CODE_W-2:0] h;
        int j;
        h = '0;
        j = 0;
        for (int p = 1; p <= LAST_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int i = 0; i < CODE_W - 1; i++) begin
                    if (p[i]) h[i] = h[i] ^ d[j];
                end
                j++;
            end
        end
        return {(^d) ^ (^h), h};
    endfunction

    // Decode: correct one data-bit flip, detect two.
    function automatic dec_t secded_decode(input logic [WORD_W-1:0] d,
                                           input logic [CODE_W-1:0] c);
        dec_t              r;
        logic [CODE_W-1:0] fresh;
        logic [CODE_W-2:0] s;
        logic              ov;
        int                j;
        fresh    = secded_encode(d);
        s        = c[CODE_W-2:0] ^ fresh[CODE_W-2:0];
        ov       = ^{d, c};
        r.data   = d;
        r.corr   = 1'b0;
        r.uncorr = 1'b0;
        if (ov) begin
            if (int'(s) > LAST_POS) begin
                r.uncorr = 1'b1;
            end else begin
                r.corr = 1'b1;
                j = 0;
                for (int p = 1; p <= LAST_POS; p++) begin
                    if ((p & (p - 1)) != 0) begin
                        if (p == int'(s)) r.data[j] = ~d[j];
                        j++;
                    end
                end
            end
        end else if (s != '0) begin
            r.uncorr = 1'b1;
        end
        return r;
    endfunction

    // One even-parity bit per byte.
    function automatic logic [NBYTES-1:0] byte_parity(input logic [WORD_W-1:0] d);
        logic [NBYTES-1:0] p;
        for (int b = 0; b < NBYTES; b++) p[b] = ^d[b*8 +: 8];
        return p;
    endfunction
endpackage

// File: rtl/ecc_write_merge.sv
// Module: builds the word to store for a host write.
// Enabled bytes take the write data (XOR the injection mask); other bytes keep
// the old value. Parity and code are computed from the clean write data.
// Assumes the old word and parity come straight from storage.
module ecc_write_merge
    import ecc_mem_pkg::*;
(
    input  logic [WORD_W-1:0] old_data,
    input  logic [NBYTES-1:0] old_par,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NBYTES-1:0] be,
    input  logic [WORD_W-1:0] inj,
    output logic [WORD_W-1:0] new_data,
    output logic [NBYTES-1:0] new_par,
    output logic [CODE_W-1:0] new_chk,
    output logic              full
);
    logic [WORD_W-1:0] clean;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Per-byte select of new versus kept contents.
        assign clean[b*8 +: 8]    = be[b] ? wdata[b*8 +: 8] : old_data[b*8 +: 8];
        assign new_data[b*8 +: 8] = be[b] ? (wdata[b*8 +: 8] ^ inj[b*8 +: 8])
                                          : old_data[b*8 +: 8];
        assign new_par[b]         = be[b] ? (^wdata[b*8 +: 8]) : old_par[b];
    end

    assign new_chk = secded_encode(clean);
    assign full    = &be;
endmodule

// File: rtl/ecc_word_check.sv
// Module: read-side check of one stored word.
// Current code: SECDED decode. Stale code: byte parity only. Bypass: raw.
// fix_o requests a write-back of data_o with code chk_o.
module ecc_word_check
    import ecc_mem_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic [CODE_W-1:0] chk_i,
    input  logic [NBYTES-1:0] par_i,
    input  logic              valid_i,
    input  logic              bypass_i,
    output logic [WORD_W-1:0] data_o,
    output logic              corr_o,
    output logic              uncorr_o,
    output logic              fix_o,
    output logic [CODE_W-1:0] chk_o
);
    dec_t dec;
    logic par_bad;

    assign dec     = secded_decode(data_i, chk_i);
    assign par_bad = (byte_parity(data_i) != par_i);

    // Pick the checking path for this word and mode.
    always_comb begin
        data_o   = data_i;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        fix_o    = 1'b0;
        if (!bypass_i) begin
            if (valid_i) begin
                data_o   = dec.data;
                corr_o   = dec.corr;
                uncorr_o = dec.uncorr;
                fix_o    = dec.corr;
            end else begin
                uncorr_o = par_bad;
                fix_o    = !par_bad;
            end
        end
    end

    assign chk_o = secded_encode(data_o);
endmodule

// File: rtl/ecc_scrub_walker.sv
// Module: address walker for the idle-time refresh.
// Advances by one (wrapping at DEPTH) only when step_i is high; holds otherwise.
module ecc_scrub_walker #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);
    // Step through addresses on idle cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          addr_o <= '0;
        else if (step_i) begin
            if (addr_o == AW'(DEPTH - 1))    addr_o <= '0;
            else                             addr_o <= addr_o + 1'b1;
        end
    end
endmodule

// File: rtl/ecc_mem_ctrl.sv
// Module: word store with SECDED, per-byte parity and a per-word code-current flag.
// Host reads answer one cycle after acceptance; a repair write-back takes the
// following cycle with ready low. Idle cycles drive the refresh walker.
// Assumes one storage write per cycle: write-back, then host write, then refresh.
module ecc_mem_ctrl
    import ecc_mem_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_disable,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [NBYTES-1:0] req_be,
    input  logic [WORD_W-1:0] inj_mask,
    output logic              ready,
    output logic              rdata_valid,
    output logic [WORD_W-1:0] rdata,
    output logic              err_corr,
    output logic              err_uncorr
);
    logic [WORD_W-1:0] data_q  [DEPTH];
    logic [CODE_W-1:0] chk_q   [DEPTH];
    logic [NBYTES-1:0] par_q   [DEPTH];
    logic              valid_q [DEPTH];

    logic              wb_pending;
    logic [AW-1:0]     wb_addr;
    logic [WORD_W-1:0] wb_data;
    logic [CODE_W-1:0] wb_chk;

    logic              accept, rd_acc, wr_acc, idle_cyc;
    logic [WORD_W-1:0] hc_data;
    logic              hc_corr, hc_uncorr, hc_fix;
    logic [CODE_W-1:0] hc_chk;
    logic [WORD_W-1:0] mg_data;
    logic [NBYTES-1:0] mg_par;
    logic [CODE_W-1:0] mg_chk;
    logic              mg_full;
    logic [AW-1:0]     scrub_addr;
    logic [WORD_W-1:0] sc_word;
    logic              sc_par_ok, scrub_fire;
    logic [CODE_W-1:0] sc_chk;

    assign ready    = !wb_pending;
    assign accept   = req_valid && ready;
    assign rd_acc   = accept && !req_write;
    assign wr_acc   = accept && req_write;
    assign idle_cyc = !req_valid && ready;

    ecc_word_check u_host_chk (
        .data_i   (data_q[req_addr]),
        .chk_i    (chk_q[req_addr]),
        .par_i    (par_q[req_addr]),
        .valid_i  (valid_q[req_addr]),
        .bypass_i (chk_disable),
        .data_o   (hc_data),
        .corr_o   (hc_corr),
        .uncorr_o (hc_uncorr),
        .fix_o    (hc_fix),
        .chk_o    (hc_chk)
    );

    ecc_write_merge u_merge (
        .old_data (data_q[req_addr]),
        .old_par  (par_q[req_addr]),
        .wdata    (req_wdata),
        .be       (req_be),
        .inj      (inj_mask),
        .new_data (mg_data),
        .new_par  (mg_par),
        .new_chk  (mg_chk),
        .full     (mg_full)
    );

    ecc_scrub_walker #(.DEPTH(DEPTH)) u_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (idle_cyc),
        .addr_o (scrub_addr)
    );

    assign sc_word    = data_q[scrub_addr];
    assign sc_par_ok  = (byte_parity(sc_word) == par_q[scrub_addr]);
    assign sc_chk     = secded_encode(sc_word);
    assign scrub_fire = idle_cyc && !valid_q[scrub_addr] && sc_par_ok;

    // Storage update: one writer per cycle in fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                data_q[i]  <= '0;
                chk_q[i]   <= '0;
                par_q[i]   <= '0;
                valid_q[i] <= 1'b1;
            end
        end else if (wb_pending) begin
            data_q[wb_addr]  <= wb_data;
            chk_q[wb_addr]   <= wb_chk;
            par_q[wb_addr]   <= byte_parity(wb_data);
            valid_q[wb_addr] <= 1'b1;
        end else if (wr_acc && (|req_be)) begin
            data_q[req_addr]  <= mg_data;
            par_q[req_addr]   <= mg_par;
            valid_q[req_addr] <= mg_full;
            if (mg_full) chk_q[req_addr] <= mg_chk;
        end else if (scrub_fire) begin
            chk_q[scrub_addr]   <= sc_chk;
            valid_q[scrub_addr] <= 1'b1;
        end
    end

    // Read response and write-back capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_valid <= 1'b0;
            rdata       <= '0;
            err_corr    <= 1'b0;
            err_uncorr  <= 1'b0;
            wb_pending  <= 1'b0;
            wb_addr     <= '0;
            wb_data     <= '0;
            wb_chk      <= '0;
        end else begin
            rdata_valid <= rd_acc;
            err_corr    <= rd_acc && hc_corr;
            err_uncorr  <= rd_acc && hc_uncorr;
            wb_pending  <= rd_acc && hc_fix;
            if (rd_acc) begin
                rdata   <= hc_data;
                wb_addr <= req_addr;
                wb_data <= hc_data;
                wb_chk  <= hc_chk;
            end
        end
    end
endmodule

// File: rtl/ecc_mem_ctrl_chk.sv
// Checker: timing and ordering properties of ecc_mem_ctrl, attached by bind.
module ecc_mem_ctrl_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chk_disable,
    input logic          req_valid,
    input logic          req_write,
    input logic          ready,
    input logic          rdata_valid,
    input logic          err_corr,
    input logic          err_uncorr,
    input logic          wb_pending,
    input logic          scrub_fire,
    input logic [AW-1:0] scrub_addr
);
    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !req_write) |=> rdata_valid);
    a_r10_no_stray_response: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(req_valid && ready && !req_write));
    a_r10_wb_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pending |=> !wb_pending);
    a_r10_wb_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pending |-> !ready);
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));
    a_r6_flags_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr) |-> rdata_valid);
    a_r7_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && !req_write && chk_disable)
        |=> (!err_corr && !err_uncorr && !wb_pending));
    a_r8_refresh_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_fire |-> (!req_valid && ready));
    a_r8_walker_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && ready) |=> (scrub_addr != $past(scrub_addr)));
    a_r9_walker_holds: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $stable(scrub_addr));
endmodule

bind ecc_mem_ctrl ecc_mem_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_disable (chk_disable),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .ready       (ready),
    .rdata_valid (rdata_valid),
    .err_corr    (err_corr),
    .err_uncorr  (err_uncorr),
    .wb_pending  (wb_pending),
    .scrub_fire  (scrub_fire),
    .scrub_addr  (scrub_addr)
);

// File: tb/tb_ecc_mem_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_ecc_mem_ctrl;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chk_disable;
    logic          req_valid;
    logic          req_write;
    logic [AW-1:0] req_addr;
    logic [63:0]   req_wdata;
    logic [7:0]    req_be;
    logic [63:0]   inj_mask;
    logic          ready, rdata_valid, err_corr, err_uncorr;
    logic [63:0]   rdata;

    int total = 0;
    int bad   = 0;

    logic [63:0] r_data;
    logic        r_v, r_c, r_u, r_rdy;

    always #5 clk = ~clk;

    ecc_mem_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .chk_disable(chk_disable),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .inj_mask(inj_mask),
        .ready(ready), .rdata_valid(rdata_valid), .rdata(rdata),
        .err_corr(err_corr), .err_uncorr(err_uncorr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] merge(input logic [63:0] o, input logic [63:0] n,
                                          input logic [7:0] be);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = be[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return m;
    endfunction

    // One request, called at a falling edge; results sampled at the next one.
    task automatic op(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                      input logic [7:0] be, input logic [63:0] inj);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a;
        req_wdata = d; req_be = be; inj_mask = inj;
        @(negedge clk);
        req_valid = 1'b0; inj_mask = '0;
        r_data = rdata; r_v = rdata_valid; r_c = err_corr; r_u = err_uncorr; r_rdy = ready;
    endtask

    task automatic rd_expect(input string req, input logic [AW-1:0] a, input logic [63:0] d,
                             input logic c, input logic u, input logic rdy);
        op(1'b0, a, '0, '0, '0);
        check({req, " data"},  r_data, d);
        check({req, " valid"}, 64'(r_v), 64'd1);
        check({req, " corr"},  64'(r_c), 64'(c));
        check({req, " uncorr"}, 64'(r_u), 64'(u));
        check({req, " ready"}, 64'(r_rdy), 64'(rdy));
    endtask

    task automatic t_reset;
        check("R10 reset ready", 64'(ready), 64'd1);
        check("R10 reset rvalid", 64'(rdata_valid), 64'd0);
        check("R10 reset flags", 64'({err_corr, err_uncorr}), 64'd0);
        rd_expect("R1 reset word", 4'd9, 64'd0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_full_write;
        op(1'b1, 4'd1, 64'h0123_4567_89AB_CDEF, 8'hFF, '0);
        check("R10 write no rvalid", 64'(r_v), 64'd0);
        rd_expect("R1 full", 4'd1, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0, 1'b1);
        op(1'b1, 4'd15, '1, 8'hFF, '0);
        rd_expect("R1 ones", 4'd15, '1, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_partial;
        logic [63:0] m;
        m = merge(64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 8'hA5);
        op(1'b1, 4'd4, 64'h1111_2222_3333_4444, 8'hFF, '0);
        op(1'b1, 4'd4, 64'hAAAA_BBBB_CCCC_DDDD, 8'hA5, '0);
        check("R2 partial no stall", 64'(r_rdy), 64'd1);
        rd_expect("R4 stale read repairs", 4'd4, m, 1'b0, 1'b0, 1'b0);
        rd_expect("R4 repaired word", 4'd4, m, 1'b0, 1'b0, 1'b1);
        op(1'b1, 4'd4, 64'hFFFF_0000_FFFF_0000, 8'h00, '0);
        rd_expect("R2 empty enables", 4'd4, m, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_parity_bad;
        logic [63:0] m;
        m = merge(64'h5555_6666_7777_8888, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F) ^ 64'h8;
        op(1'b1, 4'd6, 64'h5555_6666_7777_8888, 8'hFF, '0);
        op(1'b1, 4'd6, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F, 64'h8);
        rd_expect("R3 parity error", 4'd6, m, 1'b0, 1'b1, 1'b1);
        rd_expect("R3 still stale", 4'd6, m, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_single;
        op(1'b1, 4'd2, 64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 64'h1 << 13);
        rd_expect("R5 corrected", 4'd2, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, 1'b0, 1'b0);
        rd_expect("R5 written back", 4'd2, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 1'b1);
        op(1'b1, 4'd2, 64'h0, 8'hFF, 64'h1 << 63);
        rd_expect("R11 top bit", 4'd2, 64'h0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_double;
        logic [63:0] f;
        f = (64'h1 << 5) | (64'h1 << 40);
        op(1'b1, 4'd3, 64'h1357_9BDF_2468_ACE0, 8'hFF, f);
        rd_expect("R6 double", 4'd3, 64'h1357_9BDF_2468_ACE0 ^ f, 1'b0, 1'b1, 1'b1);
        rd_expect("R6 no repair", 4'd3, 64'h1357_9BDF_2468_ACE0 ^ f, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_bypass;
        chk_disable = 1'b1;
        op(1'b1, 4'd7, 64'h7777_0000_7777_0000, 8'hFF, 64'h1 << 20);
        rd_expect("R7 raw data", 4'd7, 64'h7777_0000_7777_0000 ^ (64'h1 << 20), 1'b0, 1'b0, 1'b1);
        chk_disable = 1'b0;
        rd_expect("R7 code kept", 4'd7, 64'h7777_0000_7777_0000, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_host_priority;
        logic [63:0] m;
        m = merge(64'd0, 64'hABCD_EF01_2345_6789, 8'h3C);
        op(1'b1, 4'd10, 64'hABCD_EF01_2345_6789, 8'h3C, '0);
        for (int i = 0; i < 3 * DEPTH; i++) op(1'b0, 4'd0, '0, '0, '0);
        rd_expect("R9 not refreshed under traffic", 4'd10, m, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_scrub;
        logic [63:0] m;
        m = merge(64'd0, 64'h0BAD_F00D_1234_5678, 8'hC3);
        op(1'b1, 4'd11, 64'h0BAD_F00D_1234_5678, 8'hC3, '0);
        repeat (DEPTH + 2) @(negedge clk);
        rd_expect("R8 refreshed when idle", 4'd11, m, 1'b0, 1'b0, 1'b1);
        rd_expect("R8 parity fault kept", 4'd6,
                  merge(64'h5555_6666_7777_8888, 64'h0F0F_0F0F_0F0F_0F0F, 8'h0F) ^ 64'h8,
                  1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; chk_disable = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_be = '0; inj_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_partial();
        t_parity_bad();
        t_single();
        t_double();
        t_bypass();
        t_host_priority();
        t_scrub();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule